// File: doc/BRIEF.md
# Escaped Packet Frame Transmitter

This block turns a result or command byte, a length and a payload into a framed byte stream for a serial transmitter. It sends one byte per handshake over a ready/valid interface. Every frame opens with a two-byte start marker and closes with a two-byte end marker. Between the markers it sends the length, the command byte, the payload and a checksum.

The payload is read from an external buffer through a read address output, with the data returned in the same cycle. The checksum is the two's complement of the 8-bit sum of the length, the command byte and the payload bytes, so that a receiver adding all four fields gets zero. The value 04h is the escape code. Wherever a length, command, payload or checksum byte equals 04h, an extra 04h goes out in front of it. Inserted escapes never enter the checksum.

An acknowledge mode builds the short reply frame on its own, using the command byte it is given. A start pulse launches a frame. A busy output stays high for the whole transmission.

Top module: `esc_frame_tx`

## Requirements
- R1: After reset, `busy` and `tx_valid` are low.
- R2: A frame is sent in this order: 02h, 04h, the length, the command byte, `len` payload bytes taken from buffer addresses 0, 1, 2 and so on, the checksum, 04h and 03h.
- R3: The checksum byte equals (0 - (length + command + sum of the payload bytes)) mod 256. Inserted escape bytes are not counted.
- R4: An extra 04h is sent immediately before any length, command, payload or checksum byte whose value is 04h. The two closing bytes 04h and 03h are never preceded by an extra 04h.
- R5: When `ack` is high at start, the frame has length 01h, command byte 06h and a single payload byte equal to `cmd`, and the buffer is not used.
- R6: A frame with length 00h goes straight from the command byte to the checksum.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold their values into the next cycle.
- R8: `busy` goes low in the cycle after the closing 03h is accepted. A `start` pulse while `busy` is high has no effect on the frame in progress and does not start another frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a frame when idle |
| ack | input | 1 | Build an acknowledge frame for `cmd` |
| len | input | 8 | Payload length in bytes |
| cmd | input | 8 | Command or result byte |
| rd_addr | output | AW | Buffer read address |
| rd_data | input | 8 | Buffer data at `rd_addr`, same cycle |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest case to reach is a stalled escape pair: a 04h field whose inserted escape has been presented but not yet accepted when `tx_ready` drops. A second hard case is a checksum that itself works out to 04h. Random `tx_ready` stalls run on every frame, and payloads are biased heavily toward 04h so that escapes meet stalls often. Directed frames put 04h in the length, the command, the payload and the checksum. One directed frame has its fields chosen so that the sum is FCh, which makes the checksum 04h.

// File: rtl/esc_frame_tx.sv
module esc_frame_tx #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ack,
  input  logic [7:0]    len,
  input  logic [7:0]    cmd,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          busy
);
  localparam logic [7:0] ESC = 8'h04;
  localparam logic [7:0] SOF = 8'h02;
  localparam logic [7:0] EOF = 8'h03;
  localparam logic [7:0] ACKV = 8'h06;

  typedef enum logic [3:0] {
    S_IDLE, S_SOF, S_ESCH, S_LEN, S_CMD, S_PAY, S_SUM, S_ESCT, S_EOF
  } st_t;

  st_t        st;
  logic [7:0] len_q, cmd_q, arg_q, sum_q, idx;
  logic       ack_q, esc_q;
  logic [7:0] body;
  logic       stuffable, need_esc, fire;

  always_comb begin
    case (st)
      S_SOF:   body = SOF;
      S_ESCH:  body = ESC;
      S_LEN:   body = len_q;
      S_CMD:   body = cmd_q;
      S_PAY:   body = ack_q ? arg_q : rd_data;
      S_SUM:   body = 8'd0 - sum_q;
      S_ESCT:  body = ESC;
      S_EOF:   body = EOF;
      default: body = 8'h00;
    endcase
  end

  assign stuffable = (st == S_LEN) || (st == S_CMD) || (st == S_PAY) || (st == S_SUM);
  assign need_esc  = stuffable && (body == ESC) && !esc_q;
  assign tx_data   = need_esc ? ESC : body;
  assign tx_valid  = (st != S_IDLE);
  assign busy      = (st != S_IDLE);
  assign fire      = tx_valid && tx_ready;
  assign rd_addr   = AW'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      len_q <= '0;
      cmd_q <= '0;
      arg_q <= '0;
      sum_q <= '0;
      idx   <= '0;
      ack_q <= 1'b0;
      esc_q <= 1'b0;
    end else if (st == S_IDLE) begin
      if (start) begin
        st    <= S_SOF;
        ack_q <= ack;
        len_q <= ack ? 8'h01 : len;
        cmd_q <= ack ? ACKV : cmd;
        arg_q <= cmd;
        idx   <= '0;
        esc_q <= 1'b0;
      end
    end else if (fire) begin
      if (need_esc) begin
        esc_q <= 1'b1;
      end else begin
        esc_q <= 1'b0;
        case (st)
          S_SOF:  st <= S_ESCH;
          S_ESCH: st <= S_LEN;
          S_LEN: begin
            sum_q <= len_q;
            st    <= S_CMD;
          end
          S_CMD: begin
            sum_q <= sum_q + cmd_q;
            st    <= (len_q == 8'd0) ? S_SUM : S_PAY;
          end
          S_PAY: begin
            sum_q <= sum_q + body;
            idx   <= idx + 8'd1;
            if (idx == len_q - 8'd1) st <= S_SUM;
          end
          S_SUM:  st <= S_ESCT;
          S_ESCT: st <= S_EOF;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && st == S_EOF) |=> !busy);

  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (tx_valid && tx_data == SOF));

  a_r4_escape_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need_esc) |=> (tx_valid && tx_data == ESC));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st != S_EOF) |=> busy);
endmodule

// File: tb/esc_frame_tx_test.sv
module esc_frame_tx_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0, ack = 0, tx_ready = 0;
  logic [7:0] len = 0, cmd = 0;
  logic [7:0] rd_addr, rd_data, tx_data;
  logic       tx_valid, busy;
  logic [7:0] mem [0:255];
  logic [7:0] expq [0:1023];
  int         exp_n;
  int         errors = 0, checks = 0;

  always #10 clk = ~clk;

  assign rd_data = mem[rd_addr];

  esc_frame_tx #(.AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ack(ack), .len(len), .cmd(cmd),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input bit stuff);
    if (stuff && b == 8'h04) begin expq[exp_n] = 8'h04; exp_n++; end
    expq[exp_n] = b; exp_n++;
  endtask

  task automatic build(input bit a, input logic [7:0] l, input logic [7:0] c);
    logic [7:0] s, el, ec;
    exp_n = 0;
    el = a ? 8'h01 : l;
    ec = a ? 8'h06 : c;
    push(8'h02, 0); push(8'h04, 0);
    push(el, 1); push(ec, 1);
    s = el + ec;
    if (a) begin push(c, 1); s = s + c; end
    else for (int i = 0; i < el; i++) begin push(mem[i], 1); s = s + mem[i]; end
    push(8'd0 - s, 1);
    push(8'h04, 0); push(8'h03, 0);
  endtask

  task automatic run_frame(input bit a, input logic [7:0] l, input logic [7:0] c,
                           input int stall_pct, input string tag, input int poke_at);
    logic [7:0] got [0:1023];
    int n = 0, cyc = 0;
    bit stalled = 0, hold_ok = 1;
    logic [7:0] prev = 0;
    bit match;
    build(a, l, c);
    @(negedge clk);
    ack = a; len = l; cmd = c; start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R2 busy after start", busy, 1);
    while (n < exp_n && cyc < 5000) begin
      if (stalled && !(tx_valid && tx_data == prev)) hold_ok = 0;
      if (n == poke_at) begin start = 1; ack = ~a; len = 8'd3; cmd = 8'h55; end
      else start = 0;
      tx_ready = ($urandom % 100) >= stall_pct;
      if (tx_valid && tx_ready) begin got[n] = tx_data; n++; stalled = 0; end
      else begin stalled = tx_valid; prev = tx_data; end
      @(negedge clk);
      cyc++;
    end
    start = 0;
    tx_ready = 0;
    check(n == exp_n, {tag, " byte count"}, n, exp_n);
    match = 1;
    for (int i = 0; i < n; i++)
      if (got[i] !== expq[i]) begin
        if (match) check(0, {tag, " byte content"}, got[i], expq[i]);
        match = 0;
      end
    if (match) check(1, tag, 0, 0);
    check(hold_ok, "R7 stall hold", hold_ok, 1);
    check(busy === 1'b0, "R8 busy low after close", busy, 0);
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && tx_valid === 1'b0, "R8 no frame from start while busy", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && tx_valid === 1'b0, "R1 reset idle", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy === 1'b0 && tx_valid === 1'b0, "R1 idle after reset", busy, 0);

    for (int i = 0; i < 8; i++) mem[i] = 8'h04;
    run_frame(0, 8'h04, 8'h04, 0, "R4 escapes all fields", -1);
    run_frame(0, 8'h04, 8'h04, 60, "R4 escapes under stall", -1);
    mem[0] = 8'h00;
    run_frame(0, 8'h01, 8'hFB, 30, "R3/R4 checksum equals 04h", -1);
    run_frame(0, 8'h00, 8'h21, 20, "R6 zero length", -1);
    run_frame(0, 8'h00, 8'h04, 50, "R6 zero length escaped command", -1);
    run_frame(1, 8'h33, 8'h04, 40, "R5 ack of 04h", -1);
    run_frame(1, 8'h00, 8'h7E, 0, "R5 ack", 3);
    run_frame(0, 8'h05, 8'h10, 30, "R8 start ignored while busy", 4);

    for (int f = 0; f < 40; f++) begin
      logic [7:0] l;
      l = 8'($urandom % 48);
      for (int i = 0; i < 48; i++) mem[i] = ($urandom % 3 == 0) ? 8'h04 : 8'($urandom);
      run_frame(($urandom % 5) == 0, l, ($urandom % 4 == 0) ? 8'h04 : 8'($urandom),
                $urandom % 70, "R2/R3/R4 random frame", ($urandom % 2) ? int'($urandom % 10) : -1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule